// File: doc/BRIEF.md
# Transmit Character Queue with Low-Water Interrupt

This block sits between a processor's write path and a serial transmitter. The processor pushes 11-bit characters into it. Each character is nine data bits, a parity bit and an address-flag bit. The transmitter pulls them out in arrival order. There are four slots. The write position and the read position advance independently, and a counter tracks how many slots are occupied.

The queue holds a latched pending-interrupt bit, so that software can refill the queue before the transmitter runs dry. The bit sets when the occupancy drops from above a programmable low-water mark to at or below it. The bit is cleared by an acknowledge pulse, or by a write that brings the occupancy back above the mark. A mask input gates the bit onto the interrupt line. A mark of zero is allowed: the bit then sets when the last character leaves the queue.

A write that arrives while all four slots are occupied is thrown away. The stored characters stay unchanged and no error is reported.

Top module: `tx_char_queue`

## Requirements
- R1: After reset, `empty` is 1, `level` is 0, `irq` is 0 and `rd_data` is 0.
- R2: Characters leave in the order they were accepted. All 11 bits are preserved. `rd_data` presents a popped character in the cycle after the `rd_en` pulse that removed it.
- R3: `level` rises by one for each accepted write and falls by one for each read of a non-empty queue. It never exceeds 4. `empty` is 1 exactly when `level` is 0.
- R4: A write while `level` is 4 and no read is requested is discarded. `level` stays 4, the stored characters are unchanged, and no output indicates the loss.
- R5: A read while `level` is 0 is ignored. `level` stays 0 and `rd_data` keeps its previous value.
- R6: A simultaneous read and write while `level` is 1, 2 or 3 performs both operations, and `level` is unchanged.
- R7: When `level` moves from `thresh+1` down to `thresh`, the pending bit sets and `irq` is 1 in the next cycle if unmasked. For example, with `thresh` = 2 the move is from 3 to 2. Occupancy already at or below the mark does not set it again.
- R8: With `thresh` = 0, the pending bit sets when the last character is read (`level` 1 to 0).
- R9: `irq` equals the pending bit while `irq_mask` is 0 and is 0 while `irq_mask` is 1. Masking does not clear the pending bit.
- R10: A cycle with `irq_ack` high clears the pending bit, unless the pending bit sets in that same cycle.
- R11: A write that raises `level` above `thresh` clears the pending bit.
- R12: The read and write positions wrap around the four slots, so first-in first-out order holds across any number of operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push strobe from the processor side |
| wr_data | input | 11 | Character to push: {address flag, parity, data[8:0]} |
| rd_en | input | 1 | Pop strobe from the transmitter |
| thresh | input | 3 | Low-water mark for the interrupt |
| irq_mask | input | 1 | 1 blocks the interrupt line |
| irq_ack | input | 1 | Clears the pending interrupt |
| rd_data | output | 11 | Most recently popped character |
| empty | output | 1 | Queue holds no characters |
| level | output | 3 | Number of occupied slots, 0 to 4 |
| irq | output | 1 | Interrupt line (pending and not masked) |

## Verification
The bench fills the queue past capacity and checks two things. If the overflow write were accepted, it would corrupt a slot or push `level` to 5, and the scoreboard would then see an out-of-order or unexpected character. The bench also reads the queue while it is empty. A design that still moved the read position would later deliver a stale slot, and one that reloaded `rd_data` would change the held value.

On the interrupt side, the bench checks each of the following:
- It crosses the mark downward, and confirms that a design using "below" rather than "at or below" stays silent.
- It sits at or below the mark without crossing, where a level-sensitive design would fire again.
- It applies the mask, acknowledge and refill clears.
- It uses a zero mark.

A simultaneous read and write at an unchanged level exposes a design that lets one of the two operations win.

// File: rtl/tx_char_queue.sv
module tx_char_queue #(
  parameter int DATA_W = 11,
  parameter int DEPTH  = 4,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [LVL_W-1:0]  thresh,
  input  logic              irq_mask,
  input  logic              irq_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic [LVL_W-1:0]  level,
  output logic              irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] ONE      = LVL_W'(1);

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [LVL_W-1:0]  lvl_nxt;
  logic              do_wr, do_rd, pend, enter, lift;

  assign do_wr = wr_en && (level != FULL_LVL);
  assign do_rd = rd_en && (level != '0);
  assign empty = (level == '0);
  assign irq   = pend && !irq_mask;

  always_comb begin
    lvl_nxt = level;
    if (do_wr && !do_rd)      lvl_nxt = level + ONE;
    else if (do_rd && !do_wr) lvl_nxt = level - ONE;
  end

  assign enter = (level > thresh) && (lvl_nxt <= thresh);
  assign lift  = do_wr && !do_rd && (lvl_nxt > thresh);

  always_ff @(posedge clk) begin
    if (do_wr) slots[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      level   <= '0;
      rd_data <= '0;
      pend    <= 1'b0;
    end else begin
      level <= lvl_nxt;
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) begin
        rptr    <= rptr + 1'b1;
        rd_data <= slots[rptr];
      end
      if (enter)                pend <= 1'b1;
      else if (irq_ack || lift) pend <= 1'b0;
    end
  end

  logic [LVL_W:0] th_up;
  assign th_up = {1'b0, thresh} + (LVL_W+1)'(1);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level == FULL_LVL && wr_en && !rd_en) |=> (level == FULL_LVL && $stable(rd_data)));
  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && rd_en && !wr_en) |=> (level == '0 && $stable(rd_data)));
  assert_rdwr_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && level != '0 && level != FULL_LVL) |=> $stable(level));
  assert_cross_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, level} == th_up && rd_en && !wr_en) |=> pend);
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !rd_en) |=> !pend);
endmodule

// File: tb/tx_char_queue_tb_top.sv
module tx_char_queue_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, irq_mask = 1'b0, irq_ack = 1'b0;
  logic [10:0] wr_data = '0;
  logic [2:0]  thresh = 3'd2;
  logic [10:0] rd_data;
  logic        empty, irq;
  logic [2:0]  level;

  int checks = 0, errors = 0, model_lvl = 0;
  logic [10:0] sb[$];

  tx_char_queue dut_i (.clk, .rst_n, .wr_en, .wr_data, .rd_en, .thresh,
    .irq_mask, .irq_ack, .rd_data, .empty, .level, .irq);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, scoreboard push on accepted writes
  task automatic op(input bit w, input logic [10:0] d, input bit r, input bit a);
    wr_en = w; wr_data = d; rd_en = r; irq_ack = a;
    if (w && model_lvl < 4) sb.push_back(d);
    model_lvl = model_lvl + ((w && model_lvl < 4) ? 1 : 0)
                          - ((r && model_lvl > 0) ? 1 : 0);
    @(posedge clk);
    #(PERIOD/4);
    wr_en = 0; rd_en = 0; irq_ack = 0;
    chk("R3 level", int'(level), model_lvl);
    chk("R3 empty", int'(empty), int'(model_lvl == 0));
  endtask

  // Monitor: compare each popped character against the scoreboard (R2, R12)
  always @(posedge clk) begin
    if (rst_n && rd_en && !empty) begin
      #1;
      if (sb.size() == 0) chk("R2 unexpected pop", 1, 0);
      else chk("R2/R12 order", int'(rd_data), int'(sb.pop_front()));
    end
  end

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD*2 + PERIOD/4);
    chk("R1 empty", int'(empty), 1);
    chk("R1 level", int'(level), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    rst_n = 1;
    @(posedge clk); #(PERIOD/4);

    // fill to four with thresh 2; rising occupancy never interrupts
    op(1, 11'h7FF, 0, 0);
    op(1, 11'h400, 0, 0);
    op(1, 11'h155, 0, 0);
    op(1, 11'h2AA, 0, 0);
    chk("R7 no irq while rising", int'(irq), 0);
    op(1, 11'h0F0, 0, 0);              // dropped
    chk("R4 full stays 4", int'(level), 4);
    chk("R4 no irq on drop", int'(irq), 0);
    op(0, 0, 1, 0);                    // 4->3
    chk("R7 no irq at 3", int'(irq), 0);
    op(0, 0, 1, 0);                    // 3->2
    chk("R7 irq on 3->2", int'(irq), 1);
    irq_mask = 1; #1;
    chk("R9 masked", int'(irq), 0);
    irq_mask = 0; #1;
    chk("R9 pending kept", int'(irq), 1);
    op(0, 0, 0, 1);
    chk("R10 ack clears", int'(irq), 0);
    op(0, 0, 1, 0);                    // 2->1 no crossing
    chk("R7 no refire below mark", int'(irq), 0);
    op(1, 11'h011, 0, 0);              // 1->2
    op(1, 11'h022, 0, 0);              // 2->3
    op(0, 0, 1, 0);                    // 3->2
    chk("R7 irq second crossing", int'(irq), 1);
    op(1, 11'h033, 0, 0);              // 2->3 lifts
    chk("R11 refill clears", int'(irq), 0);
    op(1, 11'h044, 1, 0);              // simultaneous at 3
    chk("R6 level unchanged", int'(level), 3);

    // zero mark
    thresh = 3'd0;
    op(0, 0, 1, 0);
    op(0, 0, 1, 0);
    chk("R8 no irq at 1", int'(irq), 0);
    op(0, 0, 1, 0);                    // 1->0
    chk("R8 irq at empty", int'(irq), 1);
    op(0, 0, 0, 1);
    chk("R10 ack clears", int'(irq), 0);
    op(0, 0, 1, 0);                    // read of empty
    chk("R5 rd_data held", int'(rd_data), 'h044);
    chk("R5 level 0", int'(level), 0);

    // wrap of positions across many operations (R12)
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 4; j++) op(1, 11'(k*64 + j*5 + 1), 0, 0);
      op(1, 11'h5A5, 1, 0);            // full: read taken, write dropped
      for (int j = 0; j < 3; j++) op(0, 0, 1, 0);
    end
    chk("R12 drained", int'(sb.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule